// File: doc/BRIEF.md
# PHY Configuration Packet Handler

This block receives a two-quadlet serial-bus PHY configuration packet, one 32-bit quadlet per valid beat, and applies it to the local node. The first quadlet carries a target node ID, a root-forcing flag, a gap-count-update flag and a new gap count. The second quadlet must be the exact bitwise complement of the first; no CRC protects the packet. A packet that fails this test, or that lacks the configuration type code, is dropped and reported with a one-cycle error pulse.

An accepted packet with the root flag set makes this node the forced root if the target ID equals the static local node ID. Any other node ID clears the local flag. An accepted packet with the gap flag set stores its gap count at once as a pending value. That value moves into the active gap count only when the bus-reset pulse arrives. A separate transmit formatter builds a configuration quadlet from its request fields and sends it, then its complement, on two consecutive beats. The link does not add the complement on its own, so the formatter must send it.

Top module: `phy_cfg_handler`

## Requirements
- R1: After power-on reset, force_root is 0, gap_active is 63 (GAP_INIT), the pending gap count equals the active one, pkt_err is 0 and tx_valid is 0.
- R2: Quadlets are paired in arrival order. A pair is accepted only if the second quadlet equals the bitwise inverse of the first and bits 31:30 of the first are 00. Otherwise pkt_err is high for exactly the one cycle after the second beat, and no register changes.
- R3: An accepted packet with R (bit 23) set and phy ID (bits 29:24) equal to node_id sets force_root to 1 in the cycle after the second beat.
- R4: An accepted packet with R set and a phy ID different from node_id clears force_root.
- R5: An accepted packet with R clear leaves force_root unchanged, whatever its phy ID.
- R6: An accepted packet with T (bit 22) set stores the gap count (bits 21:16) as pending at once. gap_active does not change until a bus reset.
- R7: A bus_reset pulse copies the pending gap count into gap_active. If several packets arrive before it, only the latest stored value is promoted.
- R8: An accepted packet with T clear leaves the pending gap count unchanged, whatever its gap field holds.
- R9: A packet with both R and T set performs both updates.
- R10: A tx_start pulse while idle drives tx_valid for exactly two cycles. The first beat carries the formatted quadlet and the second its bitwise inverse. A tx_start during those two cycles is ignored.
- R11: The transmitted first quadlet has bits 31:30 = 00, phy ID in 29:24, R in 23, T in 22, gap count in 21:16 and zeros in 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| node_id | input | ID_W | Static ID of the local node |
| rx_valid | input | 1 | Receive quadlet valid |
| rx_quad | input | 32 | Received quadlet |
| bus_reset | input | 1 | Bus reset pulse; promotes the pending gap count |
| tx_start | input | 1 | Request to send one configuration packet |
| tx_phy_id | input | ID_W | Target ID for the transmitted packet |
| tx_root | input | 1 | Root-forcing flag to transmit |
| tx_gap_set | input | 1 | Gap-update flag to transmit |
| tx_gap | input | GAP_W | Gap count to transmit |
| force_root | output | 1 | Local force-root flag |
| gap_active | output | GAP_W | Gap count in effect |
| pkt_err | output | 1 | One-cycle pulse for a malformed packet |
| tx_valid | output | 1 | Transmit beat valid |
| tx_quad | output | 32 | Transmit quadlet |

## Verification
The bench builds the block with ID_W = 6, GAP_W = 6 and GAP_INIT = 63, so the field positions match the 32-bit layout in R11. A local node ID of 5 gives both a matching target and a foreign one (9). Gap values 20, 10, 47 and 12 show a stored value staying hidden until the reset pulse and the latest write winning. The pending register is only seen through gap_active after a bus reset, so every gap check pairs a packet with a later reset pulse.

// File: rtl/phy_cfg_handler.sv
module phy_cfg_handler #(
  parameter int ID_W = 6,
  parameter int GAP_W = 6,
  parameter logic [GAP_W-1:0] GAP_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  node_id,
  input  logic             rx_valid,
  input  logic [31:0]      rx_quad,
  input  logic             bus_reset,
  input  logic             tx_start,
  input  logic [ID_W-1:0]  tx_phy_id,
  input  logic             tx_root,
  input  logic             tx_gap_set,
  input  logic [GAP_W-1:0] tx_gap,
  output logic             force_root,
  output logic [GAP_W-1:0] gap_active,
  output logic             pkt_err,
  output logic             tx_valid,
  output logic [31:0]      tx_quad
);
  localparam int ID_HI  = 29;
  localparam int ID_LO  = ID_HI - ID_W + 1;
  localparam int R_BIT  = ID_LO - 1;
  localparam int T_BIT  = R_BIT - 1;
  localparam int GAP_HI = T_BIT - 1;
  localparam int GAP_LO = GAP_HI - GAP_W + 1;

  logic             have_hdr;
  logic [31:0]      hdr_q;
  logic [GAP_W-1:0] gap_pending;
  logic             second_beat, hdr_ok, acc, bad;

  assign second_beat = rx_valid && have_hdr;
  assign hdr_ok      = (rx_quad == ~hdr_q) && (hdr_q[31:30] == 2'b00);
  assign acc         = second_beat && hdr_ok;
  assign bad         = second_beat && !hdr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_hdr    <= 1'b0;
      hdr_q       <= '0;
      pkt_err     <= 1'b0;
      force_root  <= 1'b0;
      gap_pending <= GAP_INIT;
      gap_active  <= GAP_INIT;
    end else begin
      if (rx_valid) begin
        have_hdr <= !have_hdr;
        if (!have_hdr) hdr_q <= rx_quad;
      end
      pkt_err <= bad;
      if (acc && hdr_q[R_BIT])
        force_root <= (hdr_q[ID_HI:ID_LO] == node_id);
      if (acc && hdr_q[T_BIT])
        gap_pending <= hdr_q[GAP_HI:GAP_LO];
      if (bus_reset)
        gap_active <= gap_pending;
    end
  end

  a_r2_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |=> !pkt_err);
  a_r2_no_update_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(force_root) && $stable(gap_pending));
  a_r5_root_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && hdr_q[R_BIT]) |=> $stable(force_root));
  a_r8_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && hdr_q[T_BIT]) |=> $stable(gap_pending));
  a_r7_active_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_reset |=> $stable(gap_active));

  logic [1:0]  tx_ph;
  logic [31:0] tx_hold, tx_fmt;

  always_comb begin
    tx_fmt = '0;
    tx_fmt[ID_HI:ID_LO]   = tx_phy_id;
    tx_fmt[R_BIT]         = tx_root;
    tx_fmt[T_BIT]         = tx_gap_set;
    tx_fmt[GAP_HI:GAP_LO] = tx_gap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ph   <= 2'd0;
      tx_hold <= '0;
    end else begin
      case (tx_ph)
        2'd0: if (tx_start) begin
          tx_ph   <= 2'd1;
          tx_hold <= tx_fmt;
        end
        2'd1: tx_ph <= 2'd2;
        default: tx_ph <= 2'd0;
      endcase
    end
  end

  assign tx_valid = (tx_ph != 2'd0);
  assign tx_quad  = (tx_ph == 2'd2) ? ~tx_hold : tx_hold;

  a_r10_inverse_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ph == 2'd1) |=> tx_valid && (tx_quad == ~$past(tx_quad)));
  a_r10_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ph == 2'd2) |=> !tx_valid);
  a_r11_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ph == 2'd1) |-> (tx_quad[31:30] == 2'b00) && (tx_quad[15:0] == 16'h0));
endmodule

// File: tb/phy_cfg_handler_test.sv
module phy_cfg_handler_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  node_id = 6'd5;
  logic        rx_valid = 0;
  logic [31:0] rx_quad = '0;
  logic        bus_reset = 0;
  logic        tx_start = 0;
  logic [5:0]  tx_phy_id = '0;
  logic        tx_root = 0;
  logic        tx_gap_set = 0;
  logic [5:0]  tx_gap = '0;
  logic        force_root;
  logic [5:0]  gap_active;
  logic        pkt_err;
  logic        tx_valid;
  logic [31:0] tx_quad;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_cfg_handler #(.ID_W(6), .GAP_W(6), .GAP_INIT(6'd63)) uut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .rx_valid(rx_valid),
    .rx_quad(rx_quad), .bus_reset(bus_reset), .tx_start(tx_start),
    .tx_phy_id(tx_phy_id), .tx_root(tx_root), .tx_gap_set(tx_gap_set),
    .tx_gap(tx_gap), .force_root(force_root), .gap_active(gap_active),
    .pkt_err(pkt_err), .tx_valid(tx_valid), .tx_quad(tx_quad));

  function automatic logic [31:0] mk(input logic [5:0] id, input logic r,
                                     input logic t, input logic [5:0] g);
    return {2'b00, id, r, t, g, 16'h0000};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] q1, input logic [31:0] q2);
    @(negedge clk); rx_valid = 1; rx_quad = q1;
    @(negedge clk); rx_quad = q2;
    @(negedge clk); rx_valid = 0; rx_quad = '0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic t_reset();
    check("R1 force_root", force_root, 0);
    check("R1 gap_active", gap_active, 63);
    check("R1 pkt_err", pkt_err, 0);
    check("R1 tx_valid", tx_valid, 0);
    pulse_reset();
    check("R1 pending equals active", gap_active, 63);
  endtask

  task automatic t_root_match();
    send(mk(5, 1, 0, 0), ~mk(5, 1, 0, 0));
    check("R3 force_root set", force_root, 1);
    check("R3 no error", pkt_err, 0);
  endtask

  task automatic t_root_other();
    send(mk(9, 1, 0, 0), ~mk(9, 1, 0, 0));
    check("R4 force_root cleared", force_root, 0);
  endtask

  task automatic t_root_ignored();
    send(mk(5, 1, 0, 0), ~mk(5, 1, 0, 0));
    send(mk(9, 0, 0, 0), ~mk(9, 0, 0, 0));
    check("R5 force_root kept with R clear", force_root, 1);
    send(mk(5, 0, 0, 0), ~mk(5, 0, 0, 0));
    check("R5 force_root kept, own id", force_root, 1);
  endtask

  task automatic t_gap_pending();
    send(mk(0, 0, 1, 20), ~mk(0, 0, 1, 20));
    check("R6 active unchanged before reset", gap_active, 63);
    repeat (3) @(negedge clk);
    check("R6 active still unchanged", gap_active, 63);
    pulse_reset();
    check("R7 active after reset", gap_active, 20);
  endtask

  task automatic t_gap_ignored();
    send(mk(5, 1, 0, 33), ~mk(5, 1, 0, 33));
    pulse_reset();
    check("R8 pending kept with T clear", gap_active, 20);
    check("R8 root still applied", force_root, 1);
  endtask

  task automatic t_gap_overwrite();
    send(mk(0, 0, 1, 10), ~mk(0, 0, 1, 10));
    send(mk(0, 0, 1, 47), ~mk(0, 0, 1, 47));
    check("R7 active held before reset", gap_active, 20);
    pulse_reset();
    check("R7 latest value promoted", gap_active, 47);
  endtask

  task automatic t_both();
    send(mk(9, 1, 1, 12), ~mk(9, 1, 1, 12));
    check("R9 root cleared", force_root, 0);
    check("R9 active held", gap_active, 47);
    pulse_reset();
    check("R9 gap promoted", gap_active, 12);
  endtask

  task automatic t_bad_inverse();
    send(mk(5, 1, 1, 3), ~mk(5, 1, 1, 3) ^ 32'h1);
    check("R2 error pulse on bad inverse", pkt_err, 1);
    check("R2 root untouched", force_root, 0);
    @(negedge clk);
    check("R2 error lasts one cycle", pkt_err, 0);
    pulse_reset();
    check("R2 pending untouched", gap_active, 12);
  endtask

  task automatic t_bad_type();
    logic [31:0] q;
    q = mk(5, 1, 1, 3) | 32'h4000_0000;
    send(q, ~q);
    check("R2 error pulse on bad type", pkt_err, 1);
    check("R2 root untouched by bad type", force_root, 0);
    pulse_reset();
    check("R2 pending untouched by bad type", gap_active, 12);
    send(mk(5, 1, 0, 0), ~mk(5, 1, 0, 0));
    check("R2 pairing intact after error", force_root, 1);
    check("R2 no error on good packet", pkt_err, 0);
  endtask

  task automatic t_tx();
    logic [31:0] exp;
    exp = 32'h2AE6_0000;
    @(negedge clk);
    tx_start = 1; tx_phy_id = 6'h2A; tx_root = 1; tx_gap_set = 1; tx_gap = 6'h26;
    @(negedge clk);
    tx_phy_id = 6'h01; tx_root = 0; tx_gap_set = 0; tx_gap = 6'h00;
    check("R10 first beat valid", tx_valid, 1);
    check("R11 first beat layout", tx_quad, exp);
    @(negedge clk);
    tx_start = 0;
    check("R10 second beat valid", tx_valid, 1);
    check("R10 second beat inverse", tx_quad, ~exp);
    @(negedge clk);
    check("R10 idle after two beats, start while busy ignored", tx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_root_match();
    t_root_other();
    t_root_ignored();
    t_gap_pending();
    t_gap_ignored();
    t_gap_overwrite();
    t_both();
    t_bad_inverse();
    t_bad_type();
    t_tx();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule